// File: doc/BRIEF.md
# Clause 22 MDIO Management Master

This block lets software reach the management registers of an external PHY over the two-wire MDC/MDIO link. Software writes the PHY address and the register number into one register. A write transaction starts when software stores a 16-bit value in the write-data register. A read transaction starts when software raises the read bit of the command register. The block then generates MDC, shifts out a complete clause 22 frame, and either drives the data phase or releases MDIO and shifts the PHY's reply in.

Two flags in the indication register report progress. BUSY is set while a frame is on the wire. NOTVALID is set while a read result is still pending. The divider field of the configuration register sets the MDC rate. Writing bit 31 of the configuration register is a soft reset: it drops any frame in progress.

The register interface uses 32-bit words selected by a word index. The index order is configuration (0), command (1), address (2), write data (3), read data (4) and indication (5). Writes take effect on the clock edge where the write strobe is high. Reads are combinational from the index.

Top module: `mdio_master`

## Requirements
- R1: After reset, MDC is low, the MDIO output enable is 0, indication reads 0, read data reads 0, and configuration reads 7.
- R2: The address word (index 2) stores the PHY address in bits 12:8 and the register number in bits 4:0. Every other bit reads back as 0.
- R3: Writing the write-data word (index 3) while idle sends the following 64 bits, MSB first, with the output enable high for the whole frame: 32 ones, 01, opcode 01, the 5-bit PHY address, the 5-bit register number, turnaround 10, and the 16 data bits. The stored value reads back in bits 15:0.
- R4: A read starts only when bit 0 of the command word (index 1) changes from 0 to 1. Writing 1 while the stored bit is already 1 starts nothing.
- R5: A read frame carries opcode 10. The output enable is high for the first 46 bits and low for the 2 turnaround bits and the 16 data bits.
- R6: The 16 bits the PHY returns are taken MSB first on rising MDC edges and appear in bits 15:0 of the read-data word (index 4).
- R7: Indication bit 0 (BUSY) rises on the edge that accepts a start and falls exactly 128×(N+1)×4 clocks later, where N is the divider field (configuration bits 2:0).
- R8: Indication bit 2 (NOTVALID) is set when a read starts and cleared on the edge that captures the read data. A write never sets it.
- R9: The MDC period is 2×(N+1)×4 clocks. MDIO changes only while MDC is low, and it is stable across each rising edge.
- R10: A start (write-data write or read request) that arrives while BUSY is set is ignored. No new frame follows it, NOTVALID is unchanged, and the write-data word keeps its old value.
- R11: A configuration write with bit 31 set aborts any frame. BUSY, NOTVALID and MDC go low, the output enable goes to 0, and bit 31 is not stored. If the abort falls on the same edge as a read completion, the abort wins and the read-data word is not updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_idx_i | input | 3 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_idx_i |
| mdc_o | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO input from the pad |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable (1 = drive) |

## Verification
Two things can land on the same clock edge. A soft reset can be written in the same cycle as the final falling MDC edge of a read, which is also the edge where the read data would be captured and NOTVALID cleared. The bench forces this by counting clocks from the read start, so that the configuration write is sampled exactly 512 clocks later with divider 0. It then checks that BUSY and NOTVALID are both clear and that the read-data word still holds the result of the previous read, not the value the PHY model was returning.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int REG_IDX_W  = 3;
  localparam int FRAME_BITS = 64;
  localparam int DATA_BITS  = 16;
  localparam int RLS_BITS   = 18; // turnaround + data released on a read

  typedef enum logic [REG_IDX_W-1:0] {
    RI_CFG   = 3'd0,
    RI_CMD   = 3'd1,
    RI_ADDR  = 3'd2,
    RI_WDATA = 3'd3,
    RI_RDATA = 3'd4,
    RI_IND   = 3'd5
  } reg_idx_e;

  localparam logic [1:0] SOF_BITS = 2'b01;
  localparam logic [1:0] OP_RD    = 2'b10;
  localparam logic [1:0] OP_WR    = 2'b01;
  localparam logic [1:0] TA_WR    = 2'b10;

  function automatic logic [FRAME_BITS-1:0] build_frame(
    input logic                 is_rd,
    input logic [4:0]           phy,
    input logic [4:0]           regn,
    input logic [DATA_BITS-1:0] dat
  );
    logic [1:0]           op;
    logic [1:0]           ta;
    logic [DATA_BITS-1:0] pay;
    op  = is_rd ? OP_RD : OP_WR;
    ta  = is_rd ? 2'b11 : TA_WR;
    pay = is_rd ? '1 : dat;
    return {32'hFFFF_FFFF, SOF_BITS, op, phy, regn, ta, pay};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W     = 3,
  parameter int BASE_MULT = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  localparam int HALF_MAX = (2 ** DIV_W) * BASE_MULT;
  localparam int CNT_W    = $clog2(HALF_MAX);

  logic [CNT_W-1:0] cnt_q;
  logic             mdc_q;
  logic [CNT_W:0]   half_len;
  logic             hit;

  assign half_len = (CNT_W+1)'((32'(div_i) + 1) * BASE_MULT);
  assign hit      = run_i && ({1'b0, cnt_q} >= (half_len - 1'b1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (hit) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign mdc_o  = mdc_q;
  assign rise_o = hit && !mdc_q;
  assign fall_o = hit && mdc_q;

  assert_stop_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !mdc_o);
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter #(
  parameter int FRAME_BITS = 64,
  parameter int DATA_BITS  = 16,
  parameter int RLS_BITS   = 18
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  abort_i,
  input  logic                  start_i,
  input  logic                  start_rd_i,
  input  logic [FRAME_BITS-1:0] frame_i,
  input  logic                  rise_i,
  input  logic                  fall_i,
  input  logic                  mdc_i,
  input  logic                  mdio_i,
  output logic                  mdio_o,
  output logic                  mdio_oe_o,
  output logic                  busy_o,
  output logic                  done_o,
  output logic [DATA_BITS-1:0]  rdata_o
);
  localparam int IDX_W = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] sh_q;
  logic [IDX_W-1:0]      idx_q;
  logic                  rd_q;
  logic                  busy_q;
  logic [DATA_BITS-1:0]  rx_q;
  logic                  last_bit;

  assign last_bit = (idx_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      idx_q  <= '0;
      rd_q   <= 1'b0;
      busy_q <= 1'b0;
      rx_q   <= '0;
    end else if (abort_i) begin
      idx_q  <= '0;
      rd_q   <= 1'b0;
      busy_q <= 1'b0;
    end else if (start_i && !busy_q) begin
      sh_q   <= frame_i;
      idx_q  <= IDX_W'(FRAME_BITS - 1);
      rd_q   <= start_rd_i;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (rise_i && rd_q && (idx_q < IDX_W'(DATA_BITS)))
        rx_q <= {rx_q[DATA_BITS-2:0], mdio_i};
      if (fall_i) begin
        if (last_bit) begin
          busy_q <= 1'b0;
        end else begin
          sh_q  <= {sh_q[FRAME_BITS-2:0], 1'b1};
          idx_q <= idx_q - 1'b1;
        end
      end
    end
  end

  assign mdio_o    = busy_q ? sh_q[FRAME_BITS-1] : 1'b1;
  assign mdio_oe_o = busy_q && !(rd_q && (idx_q < IDX_W'(RLS_BITS)));
  assign busy_o    = busy_q;
  assign done_o    = busy_q && fall_i && last_bit && !abort_i;
  assign rdata_o   = rx_q;

  assert_mdio_hold_high_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdc_i && $past(mdc_i)) |-> $stable(mdio_o));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W     = 3,
  parameter int BASE_MULT = 4,
  parameter int DIV_RST   = 7
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_we_i,
  input  logic [REG_IDX_W-1:0] reg_idx_i,
  input  logic [31:0]          reg_wdata_i,
  output logic [31:0]          reg_rdata_o,
  output logic                 mdc_o,
  input  logic                 mdio_i,
  output logic                 mdio_o,
  output logic                 mdio_oe_o
);
  logic [DIV_W-1:0]     div_q;
  logic                 rd_cmd_q;
  logic [4:0]           phy_q;
  logic [4:0]           regn_q;
  logic [DATA_BITS-1:0] wdat_q;
  logic [DATA_BITS-1:0] rdat_q;
  logic                 nv_q;

  logic wr_cfg, wr_cmd, wr_addr, wr_wdata;
  logic soft_rst, start_wr, start_rd, start;
  logic busy, done, run, rise, fall;
  logic [DATA_BITS-1:0]  rx_data;
  logic [FRAME_BITS-1:0] frame;

  assign wr_cfg   = reg_we_i && (reg_idx_i == RI_CFG);
  assign wr_cmd   = reg_we_i && (reg_idx_i == RI_CMD);
  assign wr_addr  = reg_we_i && (reg_idx_i == RI_ADDR);
  assign wr_wdata = reg_we_i && (reg_idx_i == RI_WDATA);

  assign soft_rst = wr_cfg && reg_wdata_i[31];
  assign start_wr = wr_wdata && !busy;
  assign start_rd = wr_cmd && reg_wdata_i[0] && !rd_cmd_q && !busy;
  assign start    = start_wr || start_rd;
  assign frame    = build_frame(start_rd, phy_q, regn_q, reg_wdata_i[DATA_BITS-1:0]);
  assign run      = busy && !soft_rst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q    <= DIV_W'(DIV_RST);
      rd_cmd_q <= 1'b0;
      phy_q    <= '0;
      regn_q   <= '0;
      wdat_q   <= '0;
    end else begin
      if (wr_cfg)   div_q    <= reg_wdata_i[DIV_W-1:0];
      if (wr_cmd)   rd_cmd_q <= reg_wdata_i[0];
      if (wr_addr) begin
        phy_q  <= reg_wdata_i[12:8];
        regn_q <= reg_wdata_i[4:0];
      end
      if (start_wr) wdat_q <= reg_wdata_i[DATA_BITS-1:0];
    end
  end

  // abort outranks capture on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nv_q   <= 1'b0;
      rdat_q <= '0;
    end else if (soft_rst) begin
      nv_q <= 1'b0;
    end else if (start_rd) begin
      nv_q <= 1'b1;
    end else if (done && nv_q) begin
      nv_q   <= 1'b0;
      rdat_q <= rx_data;
    end
  end

  mdio_clkgen #(
    .DIV_W     (DIV_W),
    .BASE_MULT (BASE_MULT)
  ) u_clkgen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .div_i  (div_q),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_shifter #(
    .FRAME_BITS (FRAME_BITS),
    .DATA_BITS  (DATA_BITS),
    .RLS_BITS   (RLS_BITS)
  ) u_shifter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .abort_i    (soft_rst),
    .start_i    (start),
    .start_rd_i (start_rd),
    .frame_i    (frame),
    .rise_i     (rise),
    .fall_i     (fall),
    .mdc_i      (mdc_o),
    .mdio_i     (mdio_i),
    .mdio_o     (mdio_o),
    .mdio_oe_o  (mdio_oe_o),
    .busy_o     (busy),
    .done_o     (done),
    .rdata_o    (rx_data)
  );

  always_comb begin
    unique case (reg_idx_i)
      RI_CFG:   reg_rdata_o = 32'(div_q);
      RI_CMD:   reg_rdata_o = 32'(rd_cmd_q);
      RI_ADDR:  reg_rdata_o = 32'({3'b000, phy_q, 3'b000, regn_q});
      RI_WDATA: reg_rdata_o = 32'(wdat_q);
      RI_RDATA: reg_rdata_o = 32'(rdat_q);
      RI_IND:   reg_rdata_o = 32'({nv_q, 1'b0, busy});
      default:  reg_rdata_o = '0;
    endcase
  end

  assert_nv_within_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nv_q |-> busy);
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (!mdc_o && !mdio_oe_o));
  assert_abort_clears_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> (!busy && !nv_q && !mdc_o));
  assert_busy_ignore_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_wdata && busy) |=> $stable(wdat_q));
endmodule

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
  localparam int CLK_HALF = 2;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_idx_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        mdc_o, mdio_o, mdio_oe_o;
  logic        mdio_i = 1'b1;

  int n_cmp = 0;
  int n_err = 0;

  int          rises = 0;
  int          falls = 0;
  logic [63:0] cap = '0;
  logic [63:0] oecap = '0;
  longint      t_prev = 0;
  longint      t_last = 0;
  logic [15:0] phy_val = '0;

  always #(CLK_HALF) clk = ~clk;

  mdio_master dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_idx_i   (reg_idx_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .mdc_o       (mdc_o),
    .mdio_i      (mdio_i),
    .mdio_o      (mdio_o),
    .mdio_oe_o   (mdio_oe_o)
  );

  // frame capture on MDC rising edges
  initial forever begin
    @(posedge mdc_o);
    #1;
    cap    = {cap[62:0], mdio_o};
    oecap  = {oecap[62:0], mdio_oe_o};
    rises  = rises + 1;
    t_prev = t_last;
    t_last = $time;
  end

  // PHY reply: after fall f the master is on bit 63-f; data bit i sits at f = 63-i
  initial forever begin
    @(negedge mdc_o);
    falls = falls + 1;
    if (falls >= 48 && falls <= 63) mdio_i = phy_val[63-falls];
    else mdio_i = 1'b1;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    reg_we_i = 1'b1;
    reg_idx_i = idx;
    reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] d);
    reg_idx_i = idx;
    #1;
    d = reg_rdata_o;
  endtask

  task automatic clr_mon();
    rises = 0;
    falls = 0;
    cap = '0;
    oecap = '0;
  endtask

  function automatic logic [63:0] exp_frame(input logic is_rd, input logic [4:0] p,
                                            input logic [4:0] r, input logic [15:0] d);
    if (is_rd) return {32'hFFFF_FFFF, 2'b01, 2'b10, p, r, 18'h3FFFF};
    return {32'hFFFF_FFFF, 2'b01, 2'b01, p, r, 2'b10, d};
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 mdc", 64'(mdc_o), 64'd0);
    chk("R1 oe", 64'(mdio_oe_o), 64'd0);
    rd(3'd5, v); chk("R1 ind", 64'(v), 64'd0);
    rd(3'd4, v); chk("R1 rdata", 64'(v), 64'd0);
    rd(3'd0, v); chk("R1 cfg", 64'(v), 64'd7);
  endtask

  task automatic t_addr();
    logic [31:0] v;
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, v); chk("R2 addr mask", 64'(v), 64'h1F1F);
    wr(3'd2, 32'h0000_130A);
    rd(3'd2, v); chk("R2 addr fields", 64'(v), 64'h130A);
  endtask

  task automatic t_write();
    logic [31:0] v;
    wr(3'd0, 32'd0);
    clr_mon();
    wr(3'd3, 32'h0000_A5C3);
    rd(3'd5, v); chk("R7 busy at start", 64'(v), 64'd1);
    chk("R8 no notvalid on write", 64'(v[2]), 64'd0);
    rd(3'd3, v); chk("R3 wdata readback", 64'(v), 64'hA5C3);
    repeat (511) @(negedge clk);
    rd(3'd5, v); chk("R7 busy last cycle", 64'(v), 64'd1);
    @(negedge clk);
    rd(3'd5, v); chk("R7 busy cleared", 64'(v), 64'd0);
    chk("R3 frame bits", cap, exp_frame(1'b0, 5'h13, 5'h0A, 16'hA5C3));
    chk("R3 oe whole frame", oecap, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R3 bit count", 64'(rises), 64'd64);
  endtask

  task automatic t_read(input logic [15:0] val);
    logic [31:0] v;
    wr(3'd1, 32'd0);
    clr_mon();
    phy_val = val;
    wr(3'd1, 32'd1);
    rd(3'd5, v); chk("R8 notvalid+busy at read start", 64'(v), 64'h5);
    repeat (511) @(negedge clk);
    rd(3'd5, v); chk("R8 notvalid held", 64'(v), 64'h5);
    @(negedge clk);
    rd(3'd5, v); chk("R8 notvalid cleared", 64'(v), 64'd0);
    rd(3'd4, v); chk("R6 read data", 64'(v), 64'(val));
    chk("R5 read header", 64'(cap[63:18]), 64'(exp_frame(1'b1, 5'h13, 5'h0A, 16'h0) >> 18));
    chk("R5 oe release", oecap, 64'hFFFF_FFFF_FFFC_0000);
  endtask

  task automatic t_no_retrigger();
    logic [31:0] v;
    clr_mon();
    wr(3'd1, 32'd1);
    rd(3'd5, v); chk("R4 level 1 no start", 64'(v), 64'd0);
    repeat (20) @(negedge clk);
    chk("R4 no frame", 64'(rises), 64'd0);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v;
    wr(3'd1, 32'd0);
    clr_mon();
    wr(3'd3, 32'h0000_1111);
    repeat (100) @(negedge clk);
    wr(3'd3, 32'h0000_2222);
    rd(3'd3, v); chk("R10 wdata kept", 64'(v), 64'h1111);
    wr(3'd1, 32'd1);
    rd(3'd5, v); chk("R10 read ignored", 64'(v), 64'd1);
    repeat (900) @(negedge clk);
    rd(3'd5, v); chk("R10 idle after", 64'(v), 64'd0);
    chk("R10 one frame", 64'(rises), 64'd64);
    chk("R10 first data sent", 64'(cap[15:0]), 64'h1111);
  endtask

  task automatic t_div();
    logic [31:0] v;
    wr(3'd0, 32'd1);
    clr_mon();
    wr(3'd3, 32'h0000_0F0F);
    repeat (1023) @(negedge clk);
    rd(3'd5, v); chk("R7 busy N=1 last", 64'(v), 64'd1);
    @(negedge clk);
    rd(3'd5, v); chk("R7 busy N=1 clear", 64'(v), 64'd0);
    chk("R9 mdc period", 64'(t_last - t_prev), 64'(16 * 2 * CLK_HALF));
    chk("R9 frame N=1", cap, exp_frame(1'b0, 5'h13, 5'h0A, 16'h0F0F));
    wr(3'd0, 32'd0);
  endtask

  task automatic t_abort();
    logic [31:0] v;
    logic [31:0] old;
    rd(3'd4, old);
    wr(3'd1, 32'd0);
    phy_val = 16'hBEEF;
    clr_mon();
    wr(3'd1, 32'd1);
    repeat (200) @(negedge clk);
    wr(3'd0, 32'h8000_0000);
    rd(3'd5, v); chk("R11 flags cleared", 64'(v), 64'd0);
    chk("R11 mdc low", 64'(mdc_o), 64'd0);
    chk("R11 released", 64'(mdio_oe_o), 64'd0);
    rd(3'd0, v); chk("R11 bit31 not stored", 64'(v), 64'd0);
    repeat (600) @(negedge clk);
    rd(3'd4, v); chk("R11 rdata untouched", 64'(v), 64'(old));
  endtask

  task automatic t_collide();
    logic [31:0] v;
    logic [31:0] old;
    rd(3'd4, old);
    wr(3'd1, 32'd0);
    phy_val = 16'h7777;
    clr_mon();
    wr(3'd1, 32'd1);
    repeat (510) @(negedge clk);
    wr(3'd0, 32'h8000_0000);
    rd(3'd5, v); chk("R11 collide flags", 64'(v), 64'd0);
    rd(3'd4, v); chk("R11 collide rdata", 64'(v), 64'(old));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_addr();
    t_write();
    t_read(16'h5A3C);
    t_no_retrigger();
    t_read(16'h8001);
    t_busy_ignore();
    t_div();
    t_abort();
    t_collide();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule